// File: doc/BRIEF.md
# Security Fuse Burn Sequencer

This block guards the burn strobes of two one-time security fuses. It watches register writes from the CPU and raises a burn strobe only when three writes arrive in a fixed order with exact codes. The first write unlocks the key register, the second picks one fuse through the select register, and the third writes the trim register, which starts the burn. While the burn runs, a counter adds up external microsecond ticks. Firmware ends the burn by writing zero to the trim register and then zero to the key register. The fuse is recorded as blown only when the dwell time was reached before the burn ended.

The second fuse also needs the external security pin to be high. The pin is synchronised inside the block. Its level, together with the two blown flags, is presented on a status byte that firmware can read. A wrong value or a write out of order to any watched register drops the sequence back to idle. A blown fuse cannot be selected again.

Top module: `fuse_burn_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, both burn strobes are low and status_o is 0x00.
- R2: Three writes arm a burn: 0x54 to the key register (address 0x10), then 0x81 (fuse 0) or 0x82 (fuse 1) to the select register (0x11), then 0xA6 to the trim register (0x12). The selected strobe (fuse_burn_o bit 0 or bit 1) is high from the clock edge that captures the trim write.
- R3: Once the sequence has left idle, a write to any watched register that is not the next expected write with its exact code returns the sequence to idle and drops any strobe. Writes to addresses outside the three watched registers have no effect.
- R4: In idle, only a write of 0x54 to the key register leaves idle. Any other write is ignored.
- R5: During a burn, every cycle with us_tick_i high adds one to a dwell count that saturates at DWELL_US (default 500). A trim write of 0x00 ends the burn and drops the strobe at that edge. The fuse's blown flag is set only if at least DWELL_US ticks were counted before that edge.
- R6: After the trim 0x00 write, the next watched write returns the sequence to idle, and it never arms a new sequence, even if it is 0x54 to the key register. A write to the key register while the burn is running aborts the burn without setting a blown flag.
- R7: Fuse 1 can be selected only while the synchronised security pin is high. If the pin falls while fuse 1 is selected or burning, fuse_burn_o[1] drops within two clock edges and the sequence returns to idle without setting a blown flag.
- R8: status_o bit 5 shows the security pin level two clock edges after it changes. Bits 0 and 1 are the blown flags of fuse 0 and fuse 1. All other bits read zero.
- R9: At most one strobe is high at any time. Select codes other than 0x81 or 0x82, and a second select write, abort the sequence.
- R10: A blown flag, once set, stays set until reset. Selecting a fuse whose flag is set aborts the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (8) | Register write address |
| wr_data_i | input | 8 | Register write data |
| us_tick_i | input | 1 | One-cycle microsecond tick |
| sec_pin_i | input | 1 | External security pin, asynchronous |
| fuse_burn_o | output | 2 | Burn strobes, one per fuse |
| status_o | output | 8 | Status byte: pin level in bit 5, blown flags in bits 1:0 |

## Verification
A sequencer stuck in a wrong state shows up at the strobe edge that follows the trim write. The strobe is either missing after a valid sequence or present after a corrupted one, and both cases are visible one cycle after the write. A dwell counter that is off by one shows up only in the blown flag. For that reason the boundary is tested with exactly 499 and exactly 500 ticks, and the flag is read on the status byte at the edge of the trim 0x00 write. A wrong pin path shows up as status bit 5 changing one edge too early or too late, or as the fuse 1 strobe staying high past the second edge after the pin falls.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  localparam int DATA_W    = 8;
  localparam int NUM_REG   = 3;
  localparam int REG_KEY   = 0;
  localparam int REG_SEL   = 1;
  localparam int REG_TRIM  = 2;
  localparam int STAT_PIN_BIT = 5;

  localparam logic [DATA_W-1:0] CODE_KEY      = 8'h54;
  localparam logic [DATA_W-1:0] CODE_SEL_BASE = 8'h81;
  localparam logic [DATA_W-1:0] CODE_TRIM     = 8'hA6;
  localparam logic [DATA_W-1:0] CODE_CLR      = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY,
    ST_SEL,
    ST_BURN,
    ST_CLOSE
  } seq_state_e;

  function automatic logic [DATA_W-1:0] sel_code(input int idx);
    return CODE_SEL_BASE + DATA_W'(idx);
  endfunction

endpackage

// File: rtl/fuse_wr_decode.sv
module fuse_wr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] TRIM_ADDR = 8'h12
) (
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  output logic [fuse_seq_pkg::NUM_REG-1:0]    hit_o
);
  import fuse_seq_pkg::*;

  localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REG] = '{KEY_ADDR, SEL_ADDR, TRIM_ADDR};

  for (genvar r = 0; r < NUM_REG; r++) begin : g_hit
    assign hit_o[r] = wr_en_i && (wr_addr_i == REG_ADDR[r]);
  end

endmodule

// File: rtl/fuse_pin_sync.sv
module fuse_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  assign pin_o = sync_q[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q[STAGES-1] == $past(sync_q[STAGES-2])); // R8

endmodule

// File: rtl/fuse_dwell_timer.sv
module fuse_dwell_timer #(
  parameter int DWELL_US = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CNT_W = $clog2(DWELL_US + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= CNT_W'(DWELL_US));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_COUNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm #(
  parameter int NUM_FUSE = 2,
  parameter logic [NUM_FUSE-1:0] PIN_MASK = 2'b10,
  localparam int SEL_W = (NUM_FUSE > 1) ? $clog2(NUM_FUSE) : 1
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [fuse_seq_pkg::NUM_REG-1:0]       hit_i,
  input  logic [fuse_seq_pkg::DATA_W-1:0]        data_i,
  input  logic                                   pin_ok_i,
  input  logic                                   dwell_done_i,
  output fuse_seq_pkg::seq_state_e               state_o,
  output logic [SEL_W-1:0]                       sel_o,
  output logic [NUM_FUSE-1:0]                    blown_o
);
  import fuse_seq_pkg::*;

  seq_state_e          state_q, state_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [NUM_FUSE-1:0] blown_q, blown_d;
  logic                any_hit, pin_lost;

  assign any_hit  = |hit_i;
  assign pin_lost = PIN_MASK[sel_q] && !pin_ok_i;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    blown_d = blown_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hit_i[REG_KEY] && data_i == CODE_KEY) state_d = ST_KEY;
      end
      ST_KEY: begin
        if (any_hit) begin
          state_d = ST_IDLE;
          if (hit_i[REG_SEL]) begin
            for (int f = 0; f < NUM_FUSE; f++) begin
              if (data_i == sel_code(f) && !blown_q[f] && (!PIN_MASK[f] || pin_ok_i)) begin
                state_d = ST_SEL;
                sel_d   = SEL_W'(f);
              end
            end
          end
        end
      end
      ST_SEL: begin
        if (pin_lost)     state_d = ST_IDLE;
        else if (any_hit) state_d = (hit_i[REG_TRIM] && data_i == CODE_TRIM) ? ST_BURN : ST_IDLE;
      end
      ST_BURN: begin
        if (pin_lost) state_d = ST_IDLE;
        else if (any_hit) begin
          state_d = ST_IDLE;
          if (hit_i[REG_TRIM] && data_i == CODE_CLR) begin
            state_d = ST_CLOSE;
            if (dwell_done_i) blown_d[sel_q] = 1'b1;
          end
        end
      end
      ST_CLOSE: begin
        if (any_hit) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      blown_q <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      blown_q <= blown_d;
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
  assign blown_o = blown_q;

  AST_BURN_FROM_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURN && $past(state_q) != ST_BURN) |-> $past(state_q) == ST_SEL); // R2

  AST_PIN_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SEL || state_q == ST_BURN) && PIN_MASK[sel_q] && !pin_ok_i)
      |=> state_q == ST_IDLE); // R7

  for (genvar f = 0; f < NUM_FUSE; f++) begin : g_fuse_chk
    AST_BLOWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blown_q[f] |=> blown_q[f]); // R10
    AST_BLOWN_AFTER_DWELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(blown_q[f]) |-> ($past(dwell_done_i) && state_q == ST_CLOSE)); // R5
  end

endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq #(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] TRIM_ADDR = 8'h12,
  parameter int DWELL_US    = 500,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_FUSE    = 2,
  parameter logic [NUM_FUSE-1:0] PIN_MASK = 2'b10
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [fuse_seq_pkg::DATA_W-1:0]   wr_data_i,
  input  logic                              us_tick_i,
  input  logic                              sec_pin_i,
  output logic [NUM_FUSE-1:0]               fuse_burn_o,
  output logic [fuse_seq_pkg::DATA_W-1:0]   status_o
);
  import fuse_seq_pkg::*;

  localparam int SEL_W = (NUM_FUSE > 1) ? $clog2(NUM_FUSE) : 1;

  logic [NUM_REG-1:0]  hit;
  logic                pin_ok, dwell_done, burning;
  seq_state_e          state;
  logic [SEL_W-1:0]    sel;
  logic [NUM_FUSE-1:0] blown;

  fuse_wr_decode #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .SEL_ADDR(SEL_ADDR), .TRIM_ADDR(TRIM_ADDR)
  ) u_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .hit_o    (hit)
  );

  fuse_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (sec_pin_i),
    .pin_o (pin_ok)
  );

  fuse_seq_fsm #(.NUM_FUSE(NUM_FUSE), .PIN_MASK(PIN_MASK)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .data_i      (wr_data_i),
    .pin_ok_i    (pin_ok),
    .dwell_done_i(dwell_done),
    .state_o     (state),
    .sel_o       (sel),
    .blown_o     (blown)
  );

  assign burning = (state == ST_BURN);

  fuse_dwell_timer #(.DWELL_US(DWELL_US)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (burning),
    .tick_i(us_tick_i),
    .done_o(dwell_done)
  );

  // pin-gated fuses drop their strobe as soon as the synced pin falls
  for (genvar f = 0; f < NUM_FUSE; f++) begin : g_strobe
    assign fuse_burn_o[f] = burning && (sel == SEL_W'(f)) && (!PIN_MASK[f] || pin_ok);

    AST_BURN_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fuse_burn_o[f]) |-> $past(wr_en_i && wr_addr_i == TRIM_ADDR && wr_data_i == CODE_TRIM)); // R2
  end

  always_comb begin
    status_o = '0;
    status_o[STAT_PIN_BIT]  = pin_ok;
    status_o[NUM_FUSE-1:0]  = blown;
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fuse_burn_o)); // R9

endmodule

// File: tb/tb_fuse_burn_seq.sv
`timescale 1ns/1ps
module tb_fuse_burn_seq;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b1;
  logic       pin = 1'b0;
  logic [1:0] burn;
  logic [7:0] status;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fuse_burn_seq dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .us_tick_i  (tick),
    .sec_pin_i  (pin),
    .fuse_burn_o(burn),
    .status_o   (status)
  );

  // {addr, data, expected strobes}
  localparam logic [17:0] VEC [33] = '{
    {8'h10, 8'h54, 2'b00}, {8'h11, 8'h81, 2'b00}, {8'h12, 8'hA6, 2'b01},  // R2
    {8'h20, 8'h55, 2'b01},                                               // R3 foreign address
    {8'h12, 8'h00, 2'b00}, {8'h10, 8'h00, 2'b00},                        // R5 early end
    {8'h11, 8'h81, 2'b00}, {8'h12, 8'hA6, 2'b00},                        // R4 idle
    {8'h10, 8'h54, 2'b00}, {8'h12, 8'hA6, 2'b00},                        // R3 order
    {8'h11, 8'h81, 2'b00}, {8'h12, 8'hA6, 2'b00},
    {8'h10, 8'h54, 2'b00}, {8'h11, 8'h82, 2'b00}, {8'h12, 8'hA6, 2'b00},  // R7 pin low
    {8'h10, 8'h53, 2'b00}, {8'h11, 8'h81, 2'b00}, {8'h12, 8'hA6, 2'b00},  // R4 bad key
    {8'h10, 8'h54, 2'b00}, {8'h11, 8'h83, 2'b00}, {8'h12, 8'hA6, 2'b00},  // R9 bad select
    {8'h10, 8'h54, 2'b00}, {8'h11, 8'h81, 2'b00}, {8'h11, 8'h82, 2'b00},  // R9 double select
    {8'h12, 8'hA6, 2'b00},
    {8'h10, 8'h54, 2'b00}, {8'h11, 8'h81, 2'b00}, {8'h12, 8'hA7, 2'b00},  // R3 bad trim
    {8'h10, 8'h54, 2'b00}, {8'h11, 8'h81, 2'b00}, {8'h12, 8'hA6, 2'b01},
    {8'h10, 8'h00, 2'b00},                                               // R6 key during burn
    {8'h12, 8'h00, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm(input logic [7:0] sel);
    wr(8'h10, 8'h54);
    wr(8'h11, sel);
    wr(8'h12, 8'hA6);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    check("R1 burn in reset", 32'(burn), 32'h0);
    check("R1 status in reset", 32'(status), 32'h0);
    rst_ni = 1'b1;
    wait_n(1);
    check("R1 burn after release", 32'(burn), 32'h0);
    check("R1 status after release", 32'(status), 32'h0);
    wait_n(1);

    for (int i = 0; i < 33; i++) begin
      wr(VEC[i][17:10], VEC[i][9:2]);
      check($sformatf("R2/R3 vector %0d", i), 32'(burn), 32'(VEC[i][1:0]));
    end
    check("R5 no flag after table", 32'(status), 32'h0);

    // no ticks: dwell never reached
    arm(8'h81);
    check("R2 fuse0 armed", 32'(burn), 32'h1);
    tick = 1'b0;
    wait_n(600);
    wr(8'h12, 8'h00);
    check("R5 no ticks no flag", 32'(status), 32'h0);
    wr(8'h10, 8'h00);
    tick = 1'b1;

    // key write in closing state does not arm
    arm(8'h81);
    wr(8'h12, 8'h00);
    check("R5 strobe drops on end", 32'(burn), 32'h0);
    wr(8'h10, 8'h54);
    wr(8'h11, 8'h81);
    wr(8'h12, 8'hA6);
    check("R6 closing key does not arm", 32'(burn), 32'h0);

    arm(8'h81);
    wait_n(499);
    check("R2 strobe held", 32'(burn), 32'h1);
    wr(8'h12, 8'h00);
    check("R5 499 ticks no flag", 32'(status), 32'h0);
    wr(8'h10, 8'h00);

    arm(8'h81);
    wait_n(500);
    wr(8'h12, 8'h00);
    check("R5 500 ticks flag", 32'(status), 32'h1);
    check("R5 strobe off at end", 32'(burn), 32'h0);
    wr(8'h10, 8'h00);
    check("R10 flag holds", 32'(status), 32'h1);

    arm(8'h81);
    check("R10 blown fuse not selectable", 32'(burn), 32'h0);

    pin = 1'b1;
    wait_n(1);
    check("R8 pin not yet visible", 32'(status), 32'h01);
    wait_n(1);
    check("R8 pin visible", 32'(status), 32'h21);

    arm(8'h82);
    check("R7 fuse1 armed with pin", 32'(burn), 32'h2);
    pin = 1'b0;
    wait_n(1);
    check("R7 strobe before pin reaches", 32'(burn), 32'h2);
    wait_n(1);
    check("R7 strobe drops on pin loss", 32'(burn), 32'h0);
    pin = 1'b1;
    wait_n(3);
    check("R7 sequencer left burn", 32'(burn), 32'h0);
    wr(8'h12, 8'h00);
    check("R7 no flag after pin loss", 32'(status), 32'h21);

    arm(8'h82);
    wait_n(500);
    wr(8'h12, 8'h00);
    check("R7 fuse1 blown", 32'(status), 32'h23);
    wr(8'h10, 8'h00);

    arm(8'h82);
    check("R10 fuse1 not reselectable", 32'(burn), 32'h0);
    wr(8'h10, 8'h00);
    check("R10 flags held", 32'(status), 32'h23);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule